// File: doc/BRIEF.md
# Programmable Clock Output Divider Chain

This block is the digital back end of one output of a multi-output clock generator. Two source waveforms reach it as levels oversampled by the block clock: a fast synthesized source and a raw reference. A configuration bit picks the source. The chosen waveform goes through a 5-bit divider that takes any ratio from 1 to 31, odd or even. A cascaded power-of-two stage then divides by 1, 2, 4 or 8. The divider counts both edges of the source, so every ratio produces an output with a high time of exactly half the period.

The output stage combines a master enable, shared by all outputs of the generator, with a power-down input. When the output is disabled it either floats or drives a solid 0, chosen by a configuration bit. The pad is modelled as a data bit and a separate output-enable bit. A new divider or source setting waits for the next rising output edge. A change of the master enable waits until the divided clock is low. Neither change can cut a pulse short.

Top module: `clkout_divchain`

## Requirements
- R1: While reset is held and just after it, `clk_out` is 0 and `clk_out_oe` equals `cfg_dis_low` (0 for the default floating disable).
- R2: Output period = (source period) × P × 2^S. P is the value on `cfg_pval`, and the value 0 counts as 1. S is the value on `cfg_post`: 0, 1, 2 and 3 give ÷1, ÷2, ÷4 and ÷8.
- R3: The high time of `clk_out` is exactly half its period, for odd and even P alike.
- R4: `cfg_use_ref` = 1 selects `ref_lvl` as the source, and 0 selects `vco_lvl`.
- R5: With `out_en_all` = 1 and `pwr_on` = 1, `clk_out_oe` is 1 and `clk_out` carries the divided clock.
- R6: With `out_en_all` = 0, `clk_out` stays 0. `clk_out_oe` is 0 when `cfg_dis_low` = 0 (float) and 1 when `cfg_dis_low` = 1 (driven low).
- R7: With `pwr_on` = 0, the counters stop and `clk_out` is 0 from the next cycle on, with no rising edge. The disable level follows `cfg_dis_low` as in R6. After `pwr_on` returns to 1, dividing resumes at the configured ratio.
- R8: A change of `cfg_pval`, `cfg_post` or `cfg_use_ref` takes effect at the next rising edge of the divided clock. The period in progress completes with the old setting.
- R9: A change of `out_en_all` only takes effect while the divided clock is low. Every pulse that appears on `clk_out` therefore has the full high time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock that oversamples both sources |
| rst | input | 1 | Synchronous active-high reset |
| vco_lvl | input | 1 | Fast synthesized source waveform |
| ref_lvl | input | 1 | Reference source waveform |
| cfg_use_ref | input | 1 | Source select: 1 reference, 0 fast source |
| cfg_pval | input | 5 | Main divide ratio, 0 treated as 1 |
| cfg_post | input | 2 | Post-divider exponent (÷1, ÷2, ÷4, ÷8) |
| cfg_dis_low | input | 1 | Disabled state: 0 float, 1 drive 0 |
| out_en_all | input | 1 | Shared master output enable |
| pwr_on | input | 1 | Power control, low = powered down |
| clk_out | output | 1 | Output data bit |
| clk_out_oe | output | 1 | Output driver enable (0 = high impedance) |

## Verification
The ratio is tried with P = 0 and P = 1, which must both give ÷1. It is also tried with small odd and even P on the fast source, with a mid-range P using ÷4 post division, with the largest P using ÷8, and with P = 2 using ÷2 on the slower reference. Comparing period and high time across these settings separates a wrong zero mapping, a swapped post exponent, a lost half-edge on odd ratios and a wrong source select. A ratio change made just after a rising edge shows whether the update waits for the period boundary. A burst of enable toggles at irregular offsets shows whether a truncated pulse can reach the pin. Power-down and both disable types are then checked with no rising edge allowed on the output.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

    localparam int PW    = 5;
    localparam int SW    = 2;
    localparam int QW    = (1 << SW) - 1;
    localparam int NSRC  = 2;
    localparam int SRC_VCO = 0;
    localparam int SRC_REF = 1;

    typedef struct packed {
        logic          use_ref;
        logic [PW-1:0] pval;
        logic [SW-1:0] post;
    } div_cfg_t;

    typedef enum logic {
        DIS_FLOAT = 1'b0,
        DIS_LOW   = 1'b1
    } dis_mode_e;

    function automatic logic [PW-1:0] p_last(input logic [PW-1:0] p);
        logic [PW-1:0] eff;
        eff = (p == '0) ? PW'(1) : p;
        return eff - PW'(1);
    endfunction

    function automatic logic [QW-1:0] post_last(input logic [SW-1:0] s);
        logic [QW-1:0] m;
        m = '0;
        for (int i = 0; i < QW; i++) begin
            if (i < int'(s)) m[i] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/src_edge.sv
module src_edge (
    input  logic clk,
    input  logic lvl,
    output logic edge_o
);
    logic prev_q;

    always_ff @(posedge clk) begin
        prev_q <= lvl;
    end

    assign edge_o = lvl ^ prev_q;
endmodule

// File: rtl/pdiv_stage.sv
module pdiv_stage
    import clkdiv_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          hold,
    input  logic          ev,
    input  logic [PW-1:0] last,
    output logic          pulse
);
    logic [PW-1:0] cnt_q;

    assign pulse = ev && (cnt_q == last);

    always_ff @(posedge clk) begin
        if (rst || hold) begin
            cnt_q <= '0;
        end else if (ev) begin
            cnt_q <= (cnt_q == last) ? '0 : cnt_q + PW'(1);
        end
    end

    assert_pcount_range_R2: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= last);
endmodule

// File: rtl/post_stage.sv
module post_stage
    import clkdiv_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          hold,
    input  logic          tick,
    input  logic [QW-1:0] last,
    output logic          q,
    output logic          rise
);
    logic [QW-1:0] cnt_q;
    logic          tog;

    assign tog  = tick && (cnt_q == last);
    assign rise = tog && !q;

    always_ff @(posedge clk) begin
        if (rst || hold) begin
            cnt_q <= '0;
            q     <= 1'b0;
        end else if (tick) begin
            cnt_q <= (cnt_q == last) ? '0 : cnt_q + QW'(1);
            if (tog) q <= ~q;
        end
    end

    assert_qcount_range_R2: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= last);

    assert_toggle_needs_tick_R3: assert property (@(posedge clk) disable iff (rst)
        (q != $past(q)) && $past(!hold) |-> $past(tick));
endmodule

// File: rtl/out_gate.sv
module out_gate
    import clkdiv_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      pwr_on,
    input  logic      en_all,
    input  dis_mode_e dis_mode,
    input  logic      div_q,
    output logic      dat,
    output logic      oe
);
    logic en_q;

    always_ff @(posedge clk) begin
        if (rst || !pwr_on) begin
            en_q <= 1'b0;
        end else if (!div_q) begin
            en_q <= en_all;
        end
    end

    assign dat = div_q & en_q;
    assign oe  = en_q | (dis_mode == DIS_LOW);

    assert_enable_when_low_R9: assert property (@(posedge clk) disable iff (rst)
        (en_q != $past(en_q)) && $past(pwr_on) |-> !$past(div_q));

    assert_data_implies_drive_R6: assert property (@(posedge clk) disable iff (rst)
        dat |-> oe);
endmodule

// File: rtl/clkout_divchain.sv
module clkout_divchain
    import clkdiv_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          vco_lvl,
    input  logic          ref_lvl,
    input  logic          cfg_use_ref,
    input  logic [PW-1:0] cfg_pval,
    input  logic [SW-1:0] cfg_post,
    input  logic          cfg_dis_low,
    input  logic          out_en_all,
    input  logic          pwr_on,
    output logic          clk_out,
    output logic          clk_out_oe
);
    logic [NSRC-1:0] lvl_vec;
    logic [NSRC-1:0] edg;
    div_cfg_t        cfg_in;
    div_cfg_t        act_q;
    logic            sel_ev;
    logic            p_pulse;
    logic            div_q;
    logic            rise;
    logic            load;
    logic            hold;

    assign lvl_vec[SRC_VCO] = vco_lvl;
    assign lvl_vec[SRC_REF] = ref_lvl;

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        src_edge u_edge (
            .clk    (clk),
            .lvl    (lvl_vec[g]),
            .edge_o (edg[g])
        );
    end

    assign cfg_in = '{use_ref: cfg_use_ref, pval: cfg_pval, post: cfg_post};
    assign hold   = !pwr_on;
    assign load   = rise || hold;

    always_ff @(posedge clk) begin
        if (rst || load) begin
            act_q <= cfg_in;
        end
    end

    assign sel_ev = act_q.use_ref ? edg[SRC_REF] : edg[SRC_VCO];

    pdiv_stage u_pdiv (
        .clk   (clk),
        .rst   (rst),
        .hold  (hold),
        .ev    (sel_ev),
        .last  (p_last(act_q.pval)),
        .pulse (p_pulse)
    );

    post_stage u_post (
        .clk  (clk),
        .rst  (rst),
        .hold (hold),
        .tick (p_pulse),
        .last (post_last(act_q.post)),
        .q    (div_q),
        .rise (rise)
    );

    out_gate u_gate (
        .clk      (clk),
        .rst      (rst),
        .pwr_on   (pwr_on),
        .en_all   (out_en_all),
        .dis_mode (dis_mode_e'(cfg_dis_low)),
        .div_q    (div_q),
        .dat      (clk_out),
        .oe       (clk_out_oe)
    );

    assert_cfg_at_boundary_R8: assert property (@(posedge clk) disable iff (rst)
        (act_q != $past(act_q)) |-> ($rose(div_q) || !$past(pwr_on)));

    assert_quiet_in_powerdown_R7: assert property (@(posedge clk) disable iff (rst)
        !$past(pwr_on) |-> !clk_out);
endmodule

// File: tb/tb_clkout_divchain.sv
module tb_clkout_divchain;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       vco_lvl = 1'b0;
    logic       ref_lvl = 1'b0;
    logic       cfg_use_ref = 1'b0;
    logic [4:0] cfg_pval = 5'd1;
    logic [1:0] cfg_post = 2'd0;
    logic       cfg_dis_low = 1'b0;
    logic       out_en_all = 1'b0;
    logic       pwr_on = 1'b1;
    logic       clk_out;
    logic       clk_out_oe;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int last_rise = 0;
    int last_per = 0;
    int last_hi = 0;
    int nrise = 0;
    int nfall = 0;
    int exp_hi = 0;
    int badpulse = 0;
    int ref_cnt = 0;
    logic prevo = 1'b0;

    clkout_divchain dut (
        .clk(clk), .rst(rst), .vco_lvl(vco_lvl), .ref_lvl(ref_lvl),
        .cfg_use_ref(cfg_use_ref), .cfg_pval(cfg_pval), .cfg_post(cfg_post),
        .cfg_dis_low(cfg_dis_low), .out_en_all(out_en_all), .pwr_on(pwr_on),
        .clk_out(clk_out), .clk_out_oe(clk_out_oe)
    );

    always #10 clk = ~clk;

    // fast source: half period 1 clk; reference: half period 3 clks
    always @(negedge clk) begin
        vco_lvl <= ~vco_lvl;
        if (ref_cnt == 2) begin
            ref_cnt <= 0;
            ref_lvl <= ~ref_lvl;
        end else begin
            ref_cnt <= ref_cnt + 1;
        end
    end

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (clk_out === 1'b1 && prevo == 1'b0) begin
            last_per = cyc - last_rise;
            last_rise = cyc;
            nrise = nrise + 1;
        end
        if (clk_out !== 1'b1 && prevo == 1'b1) begin
            last_hi = cyc - last_rise;
            nfall = nfall + 1;
            if (exp_hi > 0 && last_hi != exp_hi) badpulse = badpulse + 1;
        end
        prevo = (clk_out === 1'b1);
    end

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_rises(input int k);
        int target;
        target = nrise + k;
        while (nrise < target) @(negedge clk);
    endtask

    task automatic set_cfg(input logic use_ref, input int p, input int s);
        @(negedge clk);
        cfg_use_ref = use_ref;
        cfg_pval = 5'(p);
        cfg_post = 2'(s);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk("R1 data in reset", int'(clk_out), 0);
        chk("R1 oe in reset", int'(clk_out_oe), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 data after reset", int'(clk_out), 0);
        chk("R1 oe after reset", int'(clk_out_oe), 0);
    endtask

    // half-period of the source in clks is h; exp high = h*P*2^S
    task automatic t_ratio(input string tag, input logic use_ref, input int p,
                           input int s, input int exp_high);
        set_cfg(use_ref, p, s);
        wait_rises(3);
        chk({tag, " period"}, last_per, 2 * exp_high);
        chk({tag, " high time"}, last_hi, exp_high);
    endtask

    task automatic t_enable_on();
        @(negedge clk);
        out_en_all = 1'b1;
        pwr_on = 1'b1;
        set_cfg(1'b0, 3, 0);
        wait_rises(2);
        chk("R5 oe when running", int'(clk_out_oe), 1);
    endtask

    task automatic t_cfg_boundary();
        int p_old;
        set_cfg(1'b0, 3, 0);
        wait_rises(3);
        wait_rises(1);
        @(negedge clk);
        cfg_pval = 5'd5;
        wait_rises(1);
        chk("R8 old period kept", last_per, 6);
        chk("R8 old high kept", last_hi, 3);
        wait_rises(1);
        chk("R8 new period", last_per, 10);
        chk("R8 new high", last_hi, 5);
        p_old = 0;
    endtask

    task automatic t_enable_glitch();
        int bp0;
        int nf0;
        set_cfg(1'b0, 7, 0);
        wait_rises(3);
        exp_hi = 7;
        bp0 = badpulse;
        nf0 = nfall;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            out_en_all = ~out_en_all;
            repeat (((i * 5 + 3) % 11) + 2) @(negedge clk);
        end
        @(negedge clk);
        out_en_all = 1'b1;
        wait_rises(2);
        repeat (10) @(negedge clk);
        exp_hi = 0;
        chk("R9 truncated pulses", badpulse - bp0, 0);
        chk("R9 pulses seen", int'(nfall > nf0), 1);
    endtask

    task automatic t_disable();
        int r0;
        @(negedge clk);
        cfg_dis_low = 1'b0;
        out_en_all = 1'b0;
        repeat (20) @(negedge clk);
        r0 = nrise;
        chk("R6 float oe", int'(clk_out_oe), 0);
        chk("R6 float data", int'(clk_out), 0);
        cfg_dis_low = 1'b1;
        repeat (30) @(negedge clk);
        chk("R6 drive-low oe", int'(clk_out_oe), 1);
        chk("R6 drive-low data", int'(clk_out), 0);
        chk("R6 no edges while disabled", nrise - r0, 0);
        cfg_dis_low = 1'b0;
        out_en_all = 1'b1;
    endtask

    task automatic t_powerdown();
        int r0;
        set_cfg(1'b0, 9, 0);
        wait_rises(2);
        repeat (4) @(negedge clk);
        pwr_on = 1'b0;
        cfg_dis_low = 1'b0;
        @(negedge clk);
        chk("R7 data off", int'(clk_out), 0);
        chk("R7 float oe", int'(clk_out_oe), 0);
        r0 = nrise;
        cfg_dis_low = 1'b1;
        repeat (50) @(negedge clk);
        chk("R7 drive-low oe", int'(clk_out_oe), 1);
        chk("R7 no edges", nrise - r0, 0);
        cfg_dis_low = 1'b0;
        pwr_on = 1'b1;
        wait_rises(3);
        chk("R7 resume period", last_per, 18);
        chk("R7 resume high", last_hi, 9);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_enable_on();
        t_ratio("R2 P0 maps to 1", 1'b0, 0, 0, 1);
        t_ratio("R2 P1", 1'b0, 1, 0, 1);
        t_ratio("R3 odd P5 div4", 1'b0, 5, 2, 20);
        t_ratio("R2 even P6", 1'b0, 6, 0, 6);
        t_ratio("R3 odd P31 div8", 1'b0, 31, 3, 248);
        t_ratio("R4 ref P2 div2", 1'b1, 2, 1, 12);
        t_ratio("R4 back to fast P3", 1'b0, 3, 0, 3);
        t_cfg_boundary();
        t_enable_glitch();
        t_disable();
        t_powerdown();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule